// File: doc/BRIEF.md
# Weighted Min-Max Fuzzy Rule Inference Engine

This block runs the inference step of a four-input fuzzy controller. A fuzzifier upstream gives each crisp input in a compact form: the index of the lower of the two fuzzy sets the input can belong to, plus two membership degrees. One degree is for that set and the other is for the next set up. The engine rebuilds from this the degree of any set a rule asks about. It takes the minimum over a rule's four premises and scales that minimum by the rule's own 8-bit weight. It then keeps, for each of the eight output fuzzy sets, the largest weighted strength of any rule that names that set as its consequent.

Rules are held in a writable local table of up to 64 entries. A start pulse clears the eight activations and latches how many rules to run. The engine then takes one rule per clock, starting at address 0. A one-cycle done flag marks the point at which the eight activations are final. The activations stay there for a defuzzifier to read until the next start. All four premise lookups of a rule and the degree selection inside each lookup are evaluated in parallel, with no priority chain.

Top module: `fz_rule_engine`

## Requirements
- R1: A write cycle (`rule_we` high at a clock edge) stores `rule_wdata` into entry `rule_waddr`. The entry fields are:
  - bits [3k+2:3k] hold the premise set index for input k (k = 0..3);
  - bits [14:12] hold the consequent set;
  - bits [22:15] hold the weight.
- R2: After a clock edge at which `start` is high, all eight activations read zero.
- R3: With N the rule count latched at start (1..64), the block behaves as follows:
  - `busy` is high for the N cycles after the start edge;
  - `done` is high for exactly one cycle, beginning N edges after the start edge;
  - with N = 0, `done` rises at the start edge itself.
- R4: The degree of set s for input k is:
  - the low degree (`fz_lo` byte k) when s equals the input's index (`fz_idx` bits [3k+2:3k]);
  - the high degree (`fz_hi` byte k) when s equals index + 1, computed without wrap-around;
  - 0 otherwise.
- R5: A premise index of 7 means "don't care" and gives degree 255 for that input. A rule whose four premises are all 7 therefore has strength 255 before weighting.
- R6: A rule's unweighted strength is the minimum of its four premise degrees.
- R7: A rule's weighted strength is (min × weight) >> 8, truncated to 8 bits.
- R8: After done, activation j (`act` bits [8j+7:8j]) equals the maximum weighted strength over rules 0..N-1 whose consequent is j, or 0 if no rule names j.
- R9: A start pulse while a run is in progress abandons that run and begins a fresh one, with its own count and cleared activations.
- R10: The activations hold their values after done, even when the fuzzy inputs change, until the next start. A rule count above 64 is run as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rule_we | input | 1 | Rule table write strobe |
| rule_waddr | input | 6 | Rule table write address |
| rule_wdata | input | 23 | Rule entry (premises, consequent, weight) |
| rule_count | input | 7 | Number of rules to run, sampled at start |
| start | input | 1 | Clears activations and begins a run |
| fz_idx | input | 12 | Per input: lower active fuzzy set index |
| fz_lo | input | 32 | Per input: degree of the lower set |
| fz_hi | input | 32 | Per input: degree of the next set up |
| act | output | 64 | Eight 8-bit output set activations |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: activations are final |

## Verification
The assertions cover the per-cycle properties:
- activations are zero right after a start;
- no activation falls during a run;
- the done pulse lasts one cycle;
- the rule pointer stays below the latched count;
- a don't-care premise yields a full degree;
- weighting never raises a strength above its minimum.

The exact numbers can only come from the bench scenarios. These are the low/high/zero degree choice, including the no-wrap case at index 7, the truncated weighting, the maximum over rules that share a consequent, and the run latency. The bench also shows restart in mid-run, count clamping and holding after done, by comparing outputs against a model of the requirements.

// File: rtl/fz_pkg.sv
package fz_pkg;
    localparam int N_IN      = 4;
    localparam int SET_W     = 3;
    localparam int N_SETS    = 1 << SET_W;
    localparam int DEG_W     = 8;
    localparam int WT_W      = 8;
    localparam int MAX_RULES = 64;
    localparam int ADDR_W    = $clog2(MAX_RULES);
    localparam int CNT_W     = $clog2(MAX_RULES + 1);
    localparam logic [SET_W-1:0] DONT_CARE = '1;

    typedef struct packed {
        logic [WT_W-1:0]                 weight;
        logic [SET_W-1:0]                cons;
        logic [N_IN-1:0][SET_W-1:0]      prem;
    } rule_t;

    localparam int RULE_W = $bits(rule_t);
endpackage

// File: rtl/fz_rule_mem.sv
module fz_rule_mem #(
    parameter int DEPTH = 64,
    parameter int W     = 23,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [DEPTH-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fz_rule_eval.sv
module fz_rule_eval
    import fz_pkg::*;
(
    input  rule_t                      rule_i,
    input  logic [N_IN-1:0][SET_W-1:0] idx_i,
    input  logic [N_IN-1:0][DEG_W-1:0] lo_i,
    input  logic [N_IN-1:0][DEG_W-1:0] hi_i,
    output logic [N_IN-1:0][DEG_W-1:0] deg_o,
    output logic [DEG_W-1:0]           min_o,
    output logic [DEG_W-1:0]           str_o,
    output logic [SET_W-1:0]           cons_o
);
    localparam int PROD_W = DEG_W + WT_W;

    // Per-input degree rebuild: all comparisons in parallel.
    for (genvar g = 0; g < N_IN; g++) begin : g_deg
        logic [SET_W:0]   upper;
        logic [DEG_W-1:0] deg_g;
        always_comb begin
            upper = {1'b0, idx_i[g]} + 1'b1;
            if (rule_i.prem[g] == DONT_CARE) begin
                deg_g = '1;
            end else if (rule_i.prem[g] == idx_i[g]) begin
                deg_g = lo_i[g];
            end else if ({1'b0, rule_i.prem[g]} == upper) begin
                deg_g = hi_i[g];
            end else begin
                deg_g = '0;
            end
        end
        assign deg_o[g] = deg_g;
    end

    logic [PROD_W-1:0] prod;

    always_comb begin
        min_o = '1;
        for (int i = 0; i < N_IN; i++) begin
            if (deg_o[i] < min_o) begin
                min_o = deg_o[i];
            end
        end
        prod  = PROD_W'(min_o) * PROD_W'(rule_i.weight);
        str_o = prod[WT_W +: DEG_W];
    end

    assign cons_o = rule_i.cons;
endmodule

// File: rtl/fz_rule_engine.sv
module fz_rule_engine
    import fz_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rule_we,
    input  logic [ADDR_W-1:0]         rule_waddr,
    input  logic [RULE_W-1:0]         rule_wdata,
    input  logic [CNT_W-1:0]          rule_count,
    input  logic                      start,
    input  logic [N_IN*SET_W-1:0]     fz_idx,
    input  logic [N_IN*DEG_W-1:0]     fz_lo,
    input  logic [N_IN*DEG_W-1:0]     fz_hi,
    output logic [N_SETS*DEG_W-1:0]   act,
    output logic                      busy,
    output logic                      done
);
    typedef struct packed {
        logic                          busy;
        logic                          done;
        logic [ADDR_W-1:0]             ptr;
        logic [CNT_W-1:0]              cnt;
        logic [N_SETS-1:0][DEG_W-1:0]  act;
    } state_t;

    state_t st_d, st_q;

    logic [RULE_W-1:0]           rd_word;
    rule_t                       cur_rule;
    logic [N_IN-1:0][SET_W-1:0]  idx_p;
    logic [N_IN-1:0][DEG_W-1:0]  lo_p, hi_p, deg_w;
    logic [DEG_W-1:0]            min_w, str_w;
    logic [SET_W-1:0]            cons_w;
    logic [CNT_W-1:0]            cnt_clamped;

    assign idx_p    = fz_idx;
    assign lo_p     = fz_lo;
    assign hi_p     = fz_hi;
    assign cur_rule = rule_t'(rd_word);

    fz_rule_mem #(.DEPTH(MAX_RULES), .W(RULE_W)) u_mem (
        .clk   (clk),
        .we    (rule_we),
        .waddr (rule_waddr),
        .wdata (rule_wdata),
        .raddr (st_q.ptr),
        .rdata (rd_word)
    );

    fz_rule_eval u_eval (
        .rule_i (cur_rule),
        .idx_i  (idx_p),
        .lo_i   (lo_p),
        .hi_i   (hi_p),
        .deg_o  (deg_w),
        .min_o  (min_w),
        .str_o  (str_w),
        .cons_o (cons_w)
    );

    always_comb begin
        cnt_clamped = (rule_count > CNT_W'(MAX_RULES)) ? CNT_W'(MAX_RULES) : rule_count;
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.act = '0;
            st_d.ptr = '0;
            st_d.cnt = cnt_clamped;
            if (cnt_clamped == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.busy = 1'b1;
            end
        end else if (st_q.busy) begin
            if (str_w > st_q.act[cons_w]) begin
                st_d.act[cons_w] = str_w;
            end
            st_d.ptr = st_q.ptr + 1'b1;
            if (CNT_W'(st_q.ptr) + 1'b1 == st_q.cnt) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act  = st_q.act;
    assign busy = st_q.busy;
    assign done = st_q.done;

    // R3: done lasts a single cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R3: pointer never reaches the latched count during a run
    a_r3_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (CNT_W'(st_q.ptr) < st_q.cnt));

    // R2: start clears every activation
    a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.act == '0));

    // R7: weighting never raises a strength above the premise minimum
    a_r7_weight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (str_w <= min_w));

    for (genvar k = 0; k < N_SETS; k++) begin : g_chk_act
        // R8: max aggregation never lowers an activation during a run
        a_r8_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.busy && !start) |=> (st_q.act[k] >= $past(st_q.act[k])));
    end

    for (genvar k = 0; k < N_IN; k++) begin : g_chk_dc
        // R5: a don't-care premise yields full degree
        a_r5_dont_care: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.busy && cur_rule.prem[k] == DONT_CARE) |-> (deg_w[k] == '1));
    end
endmodule

// File: tb/sim_fz_rule_engine.sv
module sim_fz_rule_engine;
    import fz_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    rule_we = 1'b0;
    logic [ADDR_W-1:0]       rule_waddr = '0;
    logic [RULE_W-1:0]       rule_wdata = '0;
    logic [CNT_W-1:0]        rule_count = '0;
    logic                    start = 1'b0;
    logic [N_IN*SET_W-1:0]   fz_idx = '0;
    logic [N_IN*DEG_W-1:0]   fz_lo = '0;
    logic [N_IN*DEG_W-1:0]   fz_hi = '0;
    logic [N_SETS*DEG_W-1:0] act;
    logic                    busy, done;

    fz_rule_engine u0 (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [RULE_W-1:0] rb [MAX_RULES];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] actual, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, actual, expv);
        end
    endtask

    function automatic logic [RULE_W-1:0] mk(input int p0, input int p1, input int p2,
                                             input int p3, input int c, input int w);
        return {w[7:0], c[2:0], p3[2:0], p2[2:0], p1[2:0], p0[2:0]};
    endfunction

    function automatic int deg_f(input int p, input int ix, input int lo, input int hi);
        if (p == 7) return 255;
        if (p == ix) return lo;
        if (p == ix + 1) return hi;
        return 0;
    endfunction

    function automatic logic [63:0] model(input int n);
        logic [63:0] res = '0;
        int m, s, c, w;
        for (int r = 0; r < n; r++) begin
            m = 255;
            for (int k = 0; k < N_IN; k++) begin
                int d;
                d = deg_f(int'(rb[r][3*k +: 3]), int'(fz_idx[3*k +: 3]),
                          int'(fz_lo[8*k +: 8]), int'(fz_hi[8*k +: 8]));
                if (d < m) m = d;
            end
            c = int'(rb[r][14:12]);
            w = int'(rb[r][22:15]);
            s = (m * w) >> 8;
            if (s > int'(res[8*c +: 8])) res[8*c +: 8] = s[7:0];
        end
        return res;
    endfunction

    task automatic wr(input int a, input logic [RULE_W-1:0] d);
        @(negedge clk);
        rule_we = 1'b1; rule_waddr = a[ADDR_W-1:0]; rule_wdata = d;
        rb[a] = d;
        @(negedge clk);
        rule_we = 1'b0;
    endtask

    // Pulse start, measure latency to done, check clear/latency/pulse width.
    task automatic run(input int n, input int eff);
        int c = 0;
        @(negedge clk);
        start = 1'b1; rule_count = n[CNT_W-1:0];
        @(negedge clk);
        start = 1'b0;
        if (eff > 0) chk(act == '0, "R2", "clear after start", act, 64'd0);
        while (!done && c < 1000) begin
            @(negedge clk);
            c++;
        end
        chk(c == eff, "R3", "latency to done", 64'(c), 64'(eff));
        @(negedge clk);
        chk(!done && !busy, "R3", "done single cycle", {62'd0, busy, done}, 64'd0);
    endtask

    task automatic set_in(input int i0, input int i1, input int i2, input int i3,
                          input logic [31:0] lo, input logic [31:0] hi);
        fz_idx = {i3[2:0], i2[2:0], i1[2:0], i0[2:0]};
        fz_lo  = lo;
        fz_hi  = hi;
    endtask

    initial begin
        #1ms;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7919));
        for (int i = 0; i < MAX_RULES; i++) rb[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(act == '0 && !busy && !done, "R2", "reset state", {act[61:0], busy, done}, 64'd0);
        for (int i = 0; i < MAX_RULES; i++) wr(i, '0);

        // R4 R6 R7: low degree on input0, high degree on input1, min 120, weight 255
        wr(0, mk(2, 3, 7, 7, 4, 255));
        set_in(2, 2, 0, 0, {8'd0, 8'd0, 8'd90, 8'd200}, {8'd0, 8'd0, 8'd120, 8'd50});
        run(1, 1);
        chk(act == (64'd119 << 32), "R4", "lo/hi degree select and min", act, 64'd119 << 32);

        // R5 R7: all don't-care with full weight -> 254 on set 0
        wr(0, mk(7, 7, 7, 7, 0, 255));
        run(1, 1);
        chk(act == 64'd254, "R5", "all don't-care strength", act, 64'd254);

        // R7: half weight truncates to 127
        wr(0, mk(7, 7, 7, 7, 6, 128));
        run(1, 1);
        chk(act == (64'd127 << 48), "R7", "weight 128", act, 64'd127 << 48);

        // R4: no wrap at index 7 (premise 0 and 6 both miss)
        set_in(7, 7, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr(0, mk(0, 7, 7, 7, 1, 255));
        wr(1, mk(7, 6, 7, 7, 2, 255));
        run(2, 2);
        chk(act == '0, "R4", "no wrap / miss gives zero", act, 64'd0);

        // R8: two rules share consequent 3, max kept regardless of order
        wr(0, mk(7, 7, 7, 7, 3, 64));
        wr(1, mk(7, 7, 7, 7, 3, 128));
        wr(2, mk(7, 7, 7, 7, 5, 0));
        run(3, 3);
        chk(act == (64'd127 << 24), "R8", "max of shared consequent", act, 64'd127 << 24);

        // R3: zero count
        run(0, 0);
        chk(act == '0, "R3", "zero-rule run", act, 64'd0);

        // R1: fill full table randomly; R10 count above 64 clamps
        for (int i = 0; i < MAX_RULES; i++)
            wr(i, mk($urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8,
                     $urandom % 8, $urandom % 256));
        set_in($urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8, $urandom, $urandom);
        run(100, 64);
        chk(act == model(64), "R10", "count clamped to 64", act, model(64));

        // R10: hold after done while inputs change
        begin
            logic [63:0] held;
            held = act;
            set_in(1, 2, 3, 4, $urandom, $urandom);
            repeat (5) @(negedge clk);
            chk(act == held, "R10", "hold after done", act, held);
        end

        // R9: restart mid-run
        @(negedge clk);
        start = 1'b1; rule_count = 7'd20;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        run(5, 5);
        chk(act == model(5), "R9", "restart result", act, model(5));

        // R1 R6 R8: random rule tables and inputs
        for (int t = 0; t < 40; t++) begin
            int n;
            n = 1 + ($urandom % MAX_RULES);
            for (int i = 0; i < 6; i++) begin
                int p[4];
                for (int k = 0; k < 4; k++) p[k] = ($urandom % 4 == 0) ? 7 : $urandom % 8;
                wr($urandom % MAX_RULES, mk(p[0], p[1], p[2], p[3], $urandom % 8, $urandom % 256));
            end
            set_in($urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8, $urandom, $urandom);
            run(n, n);
            chk(act == model(n), "R8", "random rule base", act, model(n));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule